// File: doc/BRIEF.md
# Word Add-Immediate Execution Unit

This unit executes one instruction of a small 8-bit processor: it adds a 6-bit unsigned constant to a 16-bit value kept in one of four fixed register pairs near the top of a 32-byte register file. It writes the wrapped sum back into the pair and refreshes the arithmetic flags of the status register. The unit holds the register file, the status register and the program counter. Fetch, pipelining and every other arithmetic operation are outside its scope.

Instruction words arrive on a valid/ready stream. A word is transferred on a rising clock edge where both `insn_valid` and `insn_ready` are high. The unit lowers `insn_ready` only while the test load port is writing. A word that is offered while ready is low stays pending and has no effect. The results of a transferred instruction are visible just after the edge that transfers it. A transferred word that is not this instruction is consumed and changes nothing.

A test load port can write any register byte, or the whole status register, before a run. A combinational peek port reads any register byte back.

Top module: `wadd_imm_unit`

## Requirements
- R1: A transferred word whose bits 15:8 equal 0x96 is executed. Any other transferred word leaves the registers, the status register and `pc_q` unchanged.
- R2: Instruction bits 5:4 (value p) select the pair with low byte at register 24+2p and high byte at register 25+2p.
- R3: The immediate is {bits 7:6, bits 3:0} of the word, an unsigned value from 0 to 63.
- R4: The pair becomes ({high,low} + K) mod 65536. The low byte is written to the even register and the high byte to the odd one.
- R5: Status bit 3 (overflow) is set exactly when old bit 15 is 0 and new bit 15 is 1. Status bit 0 (carry) is set exactly when old bit 15 is 1 and new bit 15 is 0. For example, 0xFFFF+1 sets carry and 0xFFBF+63 does not.
- R6: Status bit 2 (negative) equals new bit 15. Bit 4 (sign) equals negative XOR overflow. Bit 1 (zero) is set only when the whole 16-bit result is zero.
- R7: Status bits 7, 6 and 5 keep their previous values across an executed instruction.
- R8: `pc_q` increases by one, modulo 2^16, for each executed instruction and for nothing else.
- R9: Reset clears `pc_q` and the status register.
- R10: `insn_ready` is low exactly while `preload_en` is high. A word offered while ready is low changes no state.
- R11: An executed instruction changes no register byte outside the selected pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit accepts the offered word this cycle |
| insn_word | input | 16 | Instruction word |
| preload_en | input | 1 | Test load write strobe |
| preload_status | input | 1 | Test load targets the status register instead of the file |
| preload_idx | input | 5 | Register byte index for a test load |
| preload_data | input | 8 | Test load data |
| peek_idx | input | 5 | Register byte index to read |
| peek_data | output | 8 | Register byte at `peek_idx`, combinational |
| status_q | output | 8 | Status register |
| pc_q | output | 16 | Program counter |

## Verification
Every piece of state is visible at the ports. The status register and the program counter are outputs. The peek port reads any register byte in the same cycle it is addressed. A wrong pair select, a wrong immediate split or a flag error therefore shows up one edge after the instruction is transferred, when the bench reads the register file and status back. Stray writes to neighbouring bytes show up in a full read-back of all 32 bytes after each pair's sweep. A miscounted program counter is caught after every single instruction.

// File: rtl/wadd_pkg.sv
package wadd_pkg;

  // Status register layout; the bench relies on these positions.
  typedef struct packed {
    logic irq_en;   // bit 7
    logic tbit;     // bit 6
    logic half;     // bit 5
    logic sgn;      // bit 4
    logic ovf;      // bit 3
    logic neg;      // bit 2
    logic zero;     // bit 1
    logic cry;      // bit 0
  } status_t;

  typedef struct packed {
    logic       hit;
    logic [1:0] pair;
    logic [5:0] imm;
  } dec_t;

endpackage

// File: rtl/wadd_decode.sv
module wadd_decode
  import wadd_pkg::*;
#(
  parameter int          IW     = 16,
  parameter logic [7:0]  OPCODE = 8'h96
) (
  input  logic [IW-1:0] word,
  output dec_t          dec
);
  always_comb begin
    dec.hit  = (word[15:8] == OPCODE);
    dec.pair = word[5:4];
    dec.imm  = {word[7:6], word[3:0]};
  end
endmodule

// File: rtl/wadd_regfile.sv
module wadd_regfile #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            ld_we,
  input  logic [AW-1:0]   ld_idx,
  input  logic [DW-1:0]   ld_data,
  input  logic            pr_we,
  input  logic [AW-1:0]   pr_lo,
  input  logic [2*DW-1:0] pr_wdata,
  output logic [2*DW-1:0] pr_rdata,
  input  logic [AW-1:0]   pk_idx,
  output logic [DW-1:0]   pk_data
);
  logic [DW-1:0] mem [NREGS];
  logic [AW-1:0] pr_hi;

  assign pr_hi = pr_lo + AW'(1);

  always_ff @(posedge clk) begin
    for (int g = 0; g < NREGS; g++) begin
      if (pr_we && pr_lo == AW'(g))
        mem[g] <= pr_wdata[DW-1:0];
      else if (pr_we && pr_hi == AW'(g))
        mem[g] <= pr_wdata[2*DW-1:DW];
      else if (ld_we && ld_idx == AW'(g))
        mem[g] <= ld_data;
    end
  end

  assign pr_rdata = {mem[pr_hi], mem[pr_lo]};
  assign pk_data  = mem[pk_idx];
endmodule

// File: rtl/wadd_flags.sv
module wadd_flags
  import wadd_pkg::*;
#(
  parameter int W  = 16,
  parameter int KW = 6
) (
  input  logic [W-1:0]  old_val,
  input  logic [KW-1:0] imm,
  input  status_t       st_in,
  output logic [W-1:0]  sum,
  output status_t       st_out
);
  always_comb begin
    sum           = old_val + W'(imm);
    st_out        = st_in;
    st_out.ovf    = ~old_val[W-1] & sum[W-1];
    st_out.cry    = old_val[W-1] & ~sum[W-1];
    st_out.neg    = sum[W-1];
    st_out.zero   = (sum == '0);
    st_out.sgn    = sum[W-1] ^ (~old_val[W-1] & sum[W-1]);
  end
endmodule

// File: rtl/wadd_imm_unit.sv
module wadd_imm_unit
  import wadd_pkg::*;
#(
  parameter int         NREGS     = 32,
  parameter int         DW        = 8,
  parameter int         PCW       = 16,
  parameter int         PAIR_BASE = 24,
  parameter logic [7:0] OPCODE    = 8'h96,
  localparam int        AW        = $clog2(NREGS),
  localparam int        WW        = 2 * DW,
  localparam int        KW        = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           insn_valid,
  output logic           insn_ready,
  input  logic [15:0]    insn_word,
  input  logic           preload_en,
  input  logic           preload_status,
  input  logic [AW-1:0]  preload_idx,
  input  logic [DW-1:0]  preload_data,
  input  logic [AW-1:0]  peek_idx,
  output logic [DW-1:0]  peek_data,
  output logic [7:0]     status_q,
  output logic [PCW-1:0] pc_q
);
  localparam logic [AW-1:0] BASE_IDX = AW'(PAIR_BASE);

  dec_t          dec;
  status_t       st_q, st_next;
  logic          take, exec;
  logic [AW-1:0] lo_idx;
  logic [WW-1:0] pair_old, pair_new;

  assign insn_ready = ~preload_en;
  assign take       = insn_valid & insn_ready;
  assign exec       = take & dec.hit;
  assign lo_idx     = BASE_IDX + AW'({dec.pair, 1'b0});

  wadd_decode #(.IW(16), .OPCODE(OPCODE)) u_dec (
    .word (insn_word),
    .dec  (dec)
  );

  wadd_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
    .clk      (clk),
    .ld_we    (preload_en & ~preload_status),
    .ld_idx   (preload_idx),
    .ld_data  (preload_data),
    .pr_we    (exec),
    .pr_lo    (lo_idx),
    .pr_wdata (pair_new),
    .pr_rdata (pair_old),
    .pk_idx   (peek_idx),
    .pk_data  (peek_data)
  );

  wadd_flags #(.W(WW), .KW(KW)) u_flg (
    .old_val (pair_old),
    .imm     (dec.imm),
    .st_in   (st_q),
    .sum     (pair_new),
    .st_out  (st_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      pc_q <= '0;
    end else begin
      if (preload_en && preload_status)
        st_q <= status_t'(preload_data[7:0]);
      else if (exec)
        st_q <= st_next;
      if (exec)
        pc_q <= pc_q + PCW'(1);
    end
  end

  assign status_q = st_q;
endmodule

// File: rtl/wadd_imm_unit_chk.sv
module wadd_imm_unit_chk #(
  parameter int PCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           insn_valid,
  input logic           insn_ready,
  input logic [15:0]    insn_word,
  input logic [7:0]     status_q,
  input logic [PCW-1:0] pc_q
);
  logic fire, other;
  assign fire  = insn_valid && insn_ready && insn_word[15:8] == 8'h96;
  assign other = insn_valid && insn_ready && insn_word[15:8] != 8'h96;

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    other |=> ($stable(status_q) && $stable(pc_q)));

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pc_q == $past(pc_q) + PCW'(1));

  assert_keep_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> status_q[7:5] == $past(status_q[7:5]));

  assert_ovf_cry_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !(status_q[3] && status_q[0]));

  assert_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> status_q[4] == (status_q[2] ^ status_q[3]));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !insn_ready) |=> $stable(pc_q));

  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |=> (pc_q == '0 && status_q == 8'h00));
endmodule

bind wadd_imm_unit wadd_imm_unit_chk #(.PCW(PCW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_valid (insn_valid),
  .insn_ready (insn_ready),
  .insn_word  (insn_word),
  .status_q   (status_q),
  .pc_q       (pc_q)
);

// File: tb/wadd_imm_unit_test.sv
module wadd_imm_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        insn_valid = 0;
  logic        insn_ready;
  logic [15:0] insn_word = '0;
  logic        preload_en = 0;
  logic        preload_status = 0;
  logic [4:0]  preload_idx = '0;
  logic [7:0]  preload_data = '0;
  logic [4:0]  peek_idx = '0;
  logic [7:0]  peek_data;
  logic [7:0]  status_q;
  logic [15:0] pc_q;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  logic [7:0]  model [32];
  logic [15:0] pc_exp = 0;

  always #10 clk = ~clk;

  wadd_imm_unit uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn_word(insn_word), .preload_en(preload_en), .preload_status(preload_status),
    .preload_idx(preload_idx), .preload_data(preload_data), .peek_idx(peek_idx),
    .peek_data(peek_data), .status_q(status_q), .pc_q(pc_q)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic load(input int idx, input logic [7:0] d, input bit st);
    @(negedge clk);
    preload_en = 1; preload_status = st; preload_idx = 5'(idx); preload_data = d;
    @(negedge clk);
    preload_en = 0; preload_status = 0;
    if (!st) model[idx] = d;
  endtask

  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    insn_valid = 1; insn_word = w;
    @(negedge clk);
    insn_valid = 0;
  endtask

  task automatic peek(input int idx, output logic [7:0] v);
    peek_idx = 5'(idx);
    #1;
    v = peek_data;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int i = 0; i < 32; i++) begin
      peek(i, v);
      check(req, {24'h0, v}, {24'h0, model[i]});
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] bases [10];
    logic [7:0]  v, lo, hi;
    logic [7:0]  st_before, st_exp;
    logic [16:0] res;
    logic [15:0] r, w;
    logic        fv, fc, fn;
    bases = '{16'h0000, 16'h00ff, 16'hffbf, 16'hffff, 16'h7fff,
              16'h8000, 16'h1234, 16'h80ff, 16'h7fc1, 16'hfffe};

    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 pc after reset", {16'h0, pc_q}, 32'h0);
    check("R9 status after reset", {24'h0, status_q}, 32'h0);
    rst_n = 1;

    for (int i = 0; i < 32; i++) load(i, 8'(i * 7 + 3), 0);
    check_all("R11 preload");

    // R10: ready low during test load, pending word has no effect
    @(negedge clk);
    preload_en = 1; preload_idx = 5'd2; preload_data = 8'h5a;
    insn_valid = 1; insn_word = 16'h9601;
    #1;
    check("R10 ready low during load", {31'h0, insn_ready}, 32'h0);
    @(negedge clk);
    preload_en = 0; insn_valid = 0; model[2] = 8'h5a;
    #1;
    check("R10 ready high after load", {31'h0, insn_ready}, 32'h1);
    check("R10 pc unchanged while stalled", {16'h0, pc_q}, {16'h0, pc_exp});
    check_all("R10 registers unchanged while stalled");

    // R1: non-matching opcodes consumed without effect
    load(0, 8'ha5, 1);
    foreach (bases[j]) begin
      w = (j % 2 == 0) ? 16'h9700 ^ 16'(j) : 16'h0096 + 16'(j << 9);
      if (w[15:8] == 8'h96) w = 16'h9500;
      issue(w);
      check("R1 other opcode pc", {16'h0, pc_q}, {16'h0, pc_exp});
      check("R1 other opcode status", {24'h0, status_q}, 32'ha5);
    end
    check_all("R1 other opcodes leave registers");

    // R2..R8: sweep all pairs, bases and immediates
    for (int d = 0; d < 4; d++) begin
      for (int b = 0; b < 10; b++) begin
        for (int k = 0; k < 64; k++) begin
          load(24 + 2 * d, bases[b][7:0], 0);
          load(25 + 2 * d, bases[b][15:8], 0);
          st_before = {3'(k >> 3), 5'h15};
          load(0, st_before, 1);
          w = 16'h9600 | 16'(d << 4) | 16'((k & 16'h30) << 2) | 16'(k & 16'hf);
          issue(w);
          res = {1'b0, bases[b]} + 17'(k);
          r   = res[15:0];
          fv  = ~bases[b][15] & r[15];
          fc  = bases[b][15] & ~r[15];
          fn  = r[15];
          st_exp = {st_before[7:5], fn ^ fv, fv, fn, (r == 16'h0), fc};
          model[24 + 2 * d] = r[7:0];
          model[25 + 2 * d] = r[15:8];
          pc_exp = pc_exp + 16'd1;
          peek(24 + 2 * d, lo);
          peek(25 + 2 * d, hi);
          check("R2 R3 R4 pair result", {16'h0, hi, lo}, {16'h0, r});
          check("R5 R6 R7 status", {24'h0, status_q}, {24'h0, st_exp});
          check("R8 pc step", {16'h0, pc_q}, {16'h0, pc_exp});
        end
      end
      check_all("R11 only selected pair written");
    end

    // R5 named corner: 0xFFFF+1 on pair 3
    load(30, 8'hff, 0); load(31, 8'hff, 0); load(0, 8'h00, 1);
    issue(16'h9631);
    pc_exp = pc_exp + 16'd1;
    check("R5 0xFFFF+1 carry and zero", {24'h0, status_q}, 32'h03);
    peek(30, v);
    check("R4 0xFFFF+1 wraps low", {24'h0, v}, 32'h0);

    // R9: reset again mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R9 pc cleared by reset", {16'h0, pc_q}, 32'h0);
    check("R9 status cleared by reset", {24'h0, status_q}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule